// File: doc/BRIEF.md
# Debug Port Pin Ownership Multiplexer

This block sits between five shared pads and two possible masters: the on-chip debug port and the general-purpose I/O controller. For every pad it picks which master supplies the output value, the output enable and the pull resistor setting. The pads are the test reset pin, the test data input, the mode-select / serial data pin, the test clock / serial clock pin and the test data output. After reset the debug port owns all five, so a debugger can attach before any software runs.

Software hands pads over to the I/O controller by writing a 3-bit configuration code on a single-cycle write strobe. The code is held in a small state machine with three named states. `OWN_FULL` keeps every pad on the debug port. `OWN_SWD` keeps only the two serial-wire pads. `OWN_GPIO` releases all five. On every write strobe the machine takes the state that the written code selects, so any of the three states can be reached from any other. While a pad is on the debug port, the pad ignores the I/O controller's settings for it. Once released, the pad follows those settings in the same cycle. The input path back to the I/O controller always carries the pad value, whichever master owns the pad.

Top module: `dbg_pin_owner`

## Requirements
- R1: Pin index order on every 5-bit bus is bit 0 test reset, bit 1 test data in, bit 2 mode-select/serial data, bit 3 test clock/serial clock, bit 4 test data out. During and right after reset all five pads are on the debug port. Pads 0, 1 and 2 get pad_pu=1 and pad_pd=0, pad 3 gets pad_pd=1 and pad_pu=0, and pad 4 gets neither pull.
- R2: While a pad is on the debug port, its pad_pu, pad_pd and pad_oe are unaffected by gpio_dir, gpio_out, gpio_pu and gpio_pd.
- R3: A pad on the debug port takes pad_out from dbg_out. Its pad_oe follows dbg_oe for pads 2 and 4 only, and is held at 0 for pads 0, 1 and 3 whatever dbg_oe says.
- R4: The configuration code resets to 000. It loads cfg_wdata on a rising clock edge where cfg_we=1 and otherwise holds. A new code acts only after that edge.
- R5: Code 010 gives pads 0, 1 and 4 to the I/O controller and keeps pads 2 and 3 on the debug port.
- R6: Code 100 gives all five pads to the I/O controller.
- R7: Code 000 and every code other than 010 and 100 (001, 011, 101, 110, 111) keep all five pads on the debug port.
- R8: A pad owned by the I/O controller has pad_out=gpio_out, pad_oe=gpio_dir (1 = output), pad_pu=gpio_pu and pad_pd=gpio_pd AND NOT gpio_pu. These follow changes in the same cycle, with no register in the path.
- R9: gpio_in equals pad_in on every pad, whatever the ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Single-cycle write strobe for the configuration code |
| cfg_wdata | input | 3 | Configuration code to load |
| gpio_dir | input | 5 | I/O controller direction per pad, 1 = output |
| gpio_out | input | 5 | I/O controller output value per pad |
| gpio_pu | input | 5 | I/O controller pull-up request per pad |
| gpio_pd | input | 5 | I/O controller pull-down request per pad |
| dbg_out | input | 5 | Debug port output value per pad |
| dbg_oe | input | 5 | Debug port output enable per pad |
| pad_in | input | 5 | Value seen at each pad |
| pad_out | output | 5 | Output value to each pad |
| pad_oe | output | 5 | Output enable to each pad |
| pad_pu | output | 5 | Pull-up enable to each pad |
| pad_pd | output | 5 | Pull-down enable to each pad |
| gpio_in | output | 5 | Pad value returned to the I/O controller |

## Verification
The bench writes all eight configuration codes. Under each code it sweeps 32 arithmetic patterns over every I/O and debug input. A decoder that fails to send the unused codes to full debug mapping would release pads under those codes. A mux that lets I/O settings through on a debug-owned pad would show the swept pull or direction at the pad. A missing force on the input-only debug pads would show dbg_oe on pads 0, 1 or 3. The bench also checks that a strobe has no effect before its clock edge and that a code is held with the strobe low. It checks that writing 000 takes pads back after a full release, and that a pull request with both pulls set resolves to pull-up. An off-by-one in the pin order or a misplaced released-pin mask would show up as a pad mismatch under code 010.

// File: rtl/dbg_pin_pkg.sv
package dbg_pin_pkg;

    localparam int unsigned PIN_N = 5;
    localparam int unsigned CFG_W = 3;

    // pad positions on every per-pin bus
    localparam int unsigned PIN_TRESET   = 0;
    localparam int unsigned PIN_TDATA_IN = 1;
    localparam int unsigned PIN_MODE_SIO = 2;
    localparam int unsigned PIN_TCLK     = 3;
    localparam int unsigned PIN_TDATA_OUT= 4;

    // configuration codes with a non-default meaning
    localparam logic [CFG_W-1:0] CODE_SWD_ONLY = 3'b010;
    localparam logic [CFG_W-1:0] CODE_ALL_GPIO = 3'b100;

    // pads kept on the debug port under the serial-wire-only code
    localparam logic [PIN_N-1:0] SWD_KEEP_MASK =
        (PIN_N'(1) << PIN_MODE_SIO) | (PIN_N'(1) << PIN_TCLK);

    // pads whose debug-side output enable is honoured
    localparam logic [PIN_N-1:0] DBG_OE_MASK =
        (PIN_N'(1) << PIN_MODE_SIO) | (PIN_N'(1) << PIN_TDATA_OUT);

    typedef enum logic [1:0] {
        OWN_FULL = 2'd0,
        OWN_SWD  = 2'd1,
        OWN_GPIO = 2'd2
    } own_state_t;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_UP   = 2'd1,
        PULL_DOWN = 2'd2
    } pull_t;

    function automatic pull_t dbg_pull_of(input int unsigned idx);
        if (idx == PIN_TCLK)           return PULL_DOWN;
        else if (idx == PIN_TDATA_OUT) return PULL_NONE;
        else                           return PULL_UP;
    endfunction

    function automatic own_state_t decode_code(input logic [CFG_W-1:0] code);
        if (code == CODE_SWD_ONLY)      return OWN_SWD;
        else if (code == CODE_ALL_GPIO) return OWN_GPIO;
        else                            return OWN_FULL;
    endfunction

endpackage

// File: rtl/dbg_own_fsm.sv
module dbg_own_fsm
    import dbg_pin_pkg::*;
#(
    parameter int unsigned NPIN = PIN_N,
    parameter int unsigned CW   = CFG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CW-1:0]   cfg_wdata,
    output logic [NPIN-1:0] dbg_own
);

    own_state_t state_q;
    own_state_t state_d;

    // next state: a strobe selects the state named by the code
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = decode_code(CFG_W'(cfg_wdata));
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OWN_FULL;
        end else begin
            state_q <= state_d;
        end
    end

    // ownership per state, 1 = debug port drives the pad
    always_comb begin
        dbg_own = '1;
        unique case (state_q)
            OWN_FULL: dbg_own = '1;
            OWN_SWD:  dbg_own = NPIN'(SWD_KEEP_MASK);
            OWN_GPIO: dbg_own = '0;
            default:  dbg_own = '1;
        endcase
    end

endmodule

// File: rtl/dbg_pin_slice.sv
module dbg_pin_slice
    import dbg_pin_pkg::*;
#(
    parameter pull_t DBG_PULL  = PULL_UP,
    parameter bit    DBG_OE_EN = 1'b0
) (
    input  logic dbg_own,
    input  logic gpio_dir,
    input  logic gpio_out,
    input  logic gpio_pu,
    input  logic gpio_pd,
    input  logic dbg_out,
    input  logic dbg_oe,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_pu,
    output logic pad_pd
);

    logic dbg_pu_fix;
    logic dbg_pd_fix;
    logic dbg_oe_eff;

    // fixed pull and enable gating chosen per pad
    generate
        if (DBG_PULL == PULL_UP) begin : g_up
            assign dbg_pu_fix = 1'b1;
            assign dbg_pd_fix = 1'b0;
        end else if (DBG_PULL == PULL_DOWN) begin : g_down
            assign dbg_pu_fix = 1'b0;
            assign dbg_pd_fix = 1'b1;
        end else begin : g_none
            assign dbg_pu_fix = 1'b0;
            assign dbg_pd_fix = 1'b0;
        end

        if (DBG_OE_EN) begin : g_oe
            assign dbg_oe_eff = dbg_oe;
        end else begin : g_in_only
            assign dbg_oe_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        if (dbg_own) begin
            pad_out = dbg_out;
            pad_oe  = dbg_oe_eff;
            pad_pu  = dbg_pu_fix;
            pad_pd  = dbg_pd_fix;
        end else begin
            pad_out = gpio_out;
            pad_oe  = gpio_dir;
            pad_pu  = gpio_pu;
            pad_pd  = gpio_pd & ~gpio_pu;
        end
    end

endmodule

// File: rtl/dbg_pin_owner.sv
module dbg_pin_owner
    import dbg_pin_pkg::*;
#(
    parameter int unsigned NPIN = PIN_N,
    parameter int unsigned CW   = CFG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CW-1:0]   cfg_wdata,
    input  logic [NPIN-1:0] gpio_dir,
    input  logic [NPIN-1:0] gpio_out,
    input  logic [NPIN-1:0] gpio_pu,
    input  logic [NPIN-1:0] gpio_pd,
    input  logic [NPIN-1:0] dbg_out,
    input  logic [NPIN-1:0] dbg_oe,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd,
    output logic [NPIN-1:0] gpio_in
);

    logic [NPIN-1:0] own_mask;

    dbg_own_fsm #(
        .NPIN (NPIN),
        .CW   (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .dbg_own   (own_mask)
    );

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            dbg_pin_slice #(
                .DBG_PULL  (dbg_pull_of(i)),
                .DBG_OE_EN (DBG_OE_MASK[i])
            ) u_slice (
                .dbg_own  (own_mask[i]),
                .gpio_dir (gpio_dir[i]),
                .gpio_out (gpio_out[i]),
                .gpio_pu  (gpio_pu[i]),
                .gpio_pd  (gpio_pd[i]),
                .dbg_out  (dbg_out[i]),
                .dbg_oe   (dbg_oe[i]),
                .pad_out  (pad_out[i]),
                .pad_oe   (pad_oe[i]),
                .pad_pu   (pad_pu[i]),
                .pad_pd   (pad_pd[i])
            );
        end
    endgenerate

    // return path is never gated by ownership
    assign gpio_in = pad_in;

endmodule

// File: rtl/dbg_pin_owner_chk.sv
module dbg_pin_owner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_wdata,
    input logic [4:0] own,
    input logic [4:0] gpio_dir,
    input logic [4:0] dbg_oe,
    input logic [4:0] pad_oe,
    input logic [4:0] pad_pu,
    input logic [4:0] pad_pd
);

    // R4: ownership holds without a strobe
    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(own));

    // R5: serial-wire-only code keeps exactly pads 2 and 3
    a_r5_swd_keeps_two: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata == 3'b010) |=> (own == 5'b01100));

    // R6: release-all code frees every pad
    a_r6_release_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata == 3'b100) |=> (own == 5'b00000));

    // R7: every other code maps all pads to debug
    a_r7_default_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata != 3'b010 && cfg_wdata != 3'b100) |=> (own == 5'b11111));

    // R1: debug-owned test clock pad pulls down only, never driven
    a_r1_tclk_pulldown: assert property (@(posedge clk) disable iff (!rst_n)
        own[3] |-> (pad_pd[3] && !pad_pu[3] && !pad_oe[3]));

    // R3: debug-owned input-only pads stay undriven whatever dbg_oe says
    a_r3_input_only_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (own[0] && dbg_oe[0]) |-> !pad_oe[0]);

    // R2: debug-owned data-in pad keeps pull-up whatever the gpio side asks
    a_r2_gpio_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (own[1] && gpio_dir[1]) |-> (pad_pu[1] && !pad_oe[1]));

    // R8: a released pad never has both pulls on
    a_r8_no_double_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu[4] && pad_pd[4]));

endmodule

bind dbg_pin_owner dbg_pin_owner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .own       (own_mask),
    .gpio_dir  (gpio_dir),
    .dbg_oe    (dbg_oe),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd)
);

// File: tb/dbg_pin_owner_bench.sv
`timescale 1ns/1ps
module dbg_pin_owner_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic [4:0] gpio_dir = '0, gpio_out = '0, gpio_pu = '0, gpio_pd = '0;
    logic [4:0] dbg_out = '0, dbg_oe = '0, pad_in = '0;
    logic [4:0] pad_out, pad_oe, pad_pu, pad_pd, gpio_in;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dbg_pin_owner u_dbg_pin_owner (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .gpio_dir(gpio_dir), .gpio_out(gpio_out), .gpio_pu(gpio_pu), .gpio_pd(gpio_pd),
        .dbg_out(dbg_out), .dbg_oe(dbg_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .gpio_in(gpio_in)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // ownership implied by a code, from R5/R6/R7
    function automatic logic [4:0] own_of(input logic [2:0] c);
        if (c == 3'b010)      return 5'b01100;
        else if (c == 3'b100) return 5'b00000;
        else                  return 5'b11111;
    endfunction

    task automatic check_all(input string tag, input logic [4:0] own);
        chk({tag, " R3 R8 pad_out"}, pad_out, (own & dbg_out) | (~own & gpio_out));
        chk({tag, " R3 R8 pad_oe"},  pad_oe,  (own & dbg_oe & 5'b10100) | (~own & gpio_dir));
        chk({tag, " R2 R8 pad_pu"},  pad_pu,  (own & 5'b00111) | (~own & gpio_pu));
        chk({tag, " R2 R8 pad_pd"},  pad_pd,  (own & 5'b01000) | (~own & gpio_pd & ~gpio_pu));
        chk("R9 gpio_in", gpio_in, pad_in);
    endtask

    task automatic write_code(input logic [2:0] c);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_pattern(input int k);
        gpio_out = 5'(k);
        gpio_dir = ~5'(k);
        gpio_pu  = 5'(k * 3);
        gpio_pd  = 5'(k * 5 + 1);
        dbg_out  = 5'(k) ^ 5'h1b;
        dbg_oe   = 5'(k * 7 + 3);
        pad_in   = 5'(k * 11 + 2);
    endtask

    initial begin
        // R1 / R2: reset state with gpio side asking for everything
        gpio_dir = '1; gpio_out = '1; gpio_pu = '0; gpio_pd = '1;
        dbg_oe = '1; dbg_out = 5'b10101; pad_in = 5'b01010;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset pad_pu", pad_pu, 5'b00111);
        chk("R1 reset pad_pd", pad_pd, 5'b01000);
        chk("R1 R3 reset pad_oe", pad_oe, 5'b10100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after reset pad_pu", pad_pu, 5'b00111);
        chk("R1 after reset pad_pd", pad_pd, 5'b01000);
        chk("R2 R3 after reset pad_out", pad_out, 5'b10101);

        // R4: strobe has no effect before its edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 3'b100;
        #1;
        chk("R4 before edge pad_pu", pad_pu, 5'b00111);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R4 R6 after edge pad_pu", pad_pu, gpio_pu);
        // R4: wdata change without strobe is held off
        cfg_wdata = 3'b000;
        repeat (2) @(negedge clk);
        #1;
        chk("R4 hold pad_oe", pad_oe, gpio_dir);
        // R4 / R7: writing 000 takes pads back
        write_code(3'b000);
        #1;
        chk("R4 R7 reclaim pad_pu", pad_pu, 5'b00111);

        // R8: both pulls requested resolve to pull-up
        write_code(3'b100);
        gpio_pu = 5'b11111; gpio_pd = 5'b11111;
        #1;
        chk("R8 double pull pad_pd", pad_pd, 5'b00000);
        chk("R8 double pull pad_pu", pad_pu, 5'b11111);

        // sweep all codes and 32 input patterns
        for (int c = 0; c < 8; c++) begin
            string tag;
            write_code(3'(c));
            if (c == 2)      tag = "R5";
            else if (c == 4) tag = "R6";
            else             tag = "R7";
            for (int k = 0; k < 32; k++) begin
                @(negedge clk);
                set_pattern(k);
                #1;
                check_all(tag, own_of(3'(c)));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule